// File: doc/BRIEF.md
# 16-bit Timer with Clear-on-Compare Mode

This block is an up-counting timer of parameterised width (16 bits by default). It steps forward on each clock cycle in which its timer-clock enable is high. A four-bit mode code selects how it runs. In free-running mode it wraps from all ones to zero, and a sticky overflow flag records each wrap. In the two clear-on-compare modes the count returns to zero after it reaches a top value. Depending on the mode code, that top value comes from compare register A or from the capture/top register.

On every advancing cycle the count is compared with compare register A. A match sets a sticky compare flag and acts on one output pin, as chosen by a two-bit output-action field. Software reaches the count, both registers and the control word through a plain single-cycle register port with a combinational read path. It clears the flags either through dedicated acknowledge inputs or by writing 1 to the flag bits. The block has no streaming data path, so no valid/ready handshake applies. Every pin is a plain control or status signal.

Register addresses: 0 count, 1 compare A, 2 capture/top, 3 control (mode code in bits 3:0, output action in bits 5:4), 4 flags (bit 0 overflow, bit 1 compare-match).

Top module: `tmr16_ctc`

## Requirements
- R1: After reset the count, compare A, capture/top and control registers read 0, both flags are 0 and the output pin is 0.
- R2: The count changes only on cycles where `tick` is high or the count is written; on all other cycles it holds.
- R3: With mode code 0, each advancing cycle adds one, the count wraps from 0xFFFF to 0x0000, and a match with compare A never clears it.
- R4: The overflow flag is set on the same clock edge at which an advancing cycle moves the count from all ones to zero, and counting never clears it.
- R5: The overflow flag is cleared by `ovf_ack` or by writing 1 to bit 0 at address 4; when a set and a clear coincide, the set wins.
- R6: With mode code 4, an advancing cycle that finds the count equal to compare A loads zero, so the period is compare A plus one.
- R7: With mode code 12, an advancing cycle that finds the count equal to the capture/top register loads zero; compare A does not clear the count.
- R8: The compare flag is set by any advancing cycle with the count equal to compare A in any mode, and is cleared by `cmp_ack` or by writing 1 to bit 1 at address 4 (without touching bit 0).
- R9: On the edge of a match, output action 00 leaves the pin alone, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R10: A write to the count takes priority: the written value appears after that edge whatever `tick` is, and that cycle produces no match.
- R11: Mode codes other than 0, 4 and 12 behave exactly like mode 0.
- R12: The output-action field has no effect on the counting sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer-clock enable; the count advances on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Combinational read data for `addr` |
| ovf_ack | input | 1 | Overflow interrupt acknowledge, clears the overflow flag |
| cmp_ack | input | 1 | Compare interrupt acknowledge, clears the compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| oc_pin | output | 1 | Output-compare pin |

## Verification
On every cycle the assertions check that the count holds without a tick, steps by one in free-running mode, reloads to zero after a top hit in either clear mode, and takes a written value. They also check that the flags stay set until a clear arrives, and that the pin is stable except on matches with an active action. Only the directed scenarios can show the exact edge on which overflow appears against the wrap, that set beats acknowledge, that reserved mode codes fall back to free running, and that the output-action field leaves the period untouched.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;

  typedef enum logic [1:0] {RUN_FREE, RUN_CLR_A, RUN_CLR_T} run_e;
  typedef enum logic [1:0] {OC_OFF = 2'b00, OC_TOG = 2'b01,
                            OC_CLR = 2'b10, OC_SET = 2'b11} oc_e;

  function automatic run_e decode_mode(input logic [3:0] code);
    case (code)
      4'd4:    return RUN_CLR_A;
      4'd12:   return RUN_CLR_T;
      default: return RUN_FREE;
    endcase
  endfunction
endpackage

// File: rtl/tmr16_regs.sv
`timescale 1ns/1ps
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  cmpa,
  output logic [CNT_W-1:0]  topv,
  output logic [3:0]        mode_code,
  output oc_e               oc_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpa      <= '0;
      topv      <= '0;
      mode_code <= '0;
      oc_mode   <= OC_OFF;
    end else if (wr_en) begin
      case (addr)
        A_CMPA: cmpa <= wdata;
        A_TOP:  topv <= wdata;
        A_CTRL: begin
          mode_code <= wdata[3:0];
          oc_mode   <= oc_e'(wdata[5:4]);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmr16_core.sv
`timescale 1ns/1ps
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  run_e             run,
  input  logic [CNT_W-1:0] cmpa,
  input  logic [CNT_W-1:0] topv,
  output logic [CNT_W-1:0] cnt,
  output logic             match_ev,
  output logic             wrap_ev
);
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic adv;
  logic top_hit;

  assign adv      = tick && !cnt_wr;
  assign top_hit  = ((run == RUN_CLR_A) && (cnt == cmpa)) ||
                    ((run == RUN_CLR_T) && (cnt == topv));
  assign match_ev = adv && (cnt == cmpa);
  assign wrap_ev  = adv && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cnt_wr)  cnt <= cnt_wdata;
    else if (adv)     cnt <= top_hit ? '0 : cnt + ONE;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && run == RUN_FREE) |=> (cnt == ($past(cnt) + ONE)));
  assert_clr_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && run == RUN_CLR_A && cnt == cmpa) |=> (cnt == '0));
  assert_clr_t_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && run == RUN_CLR_T && cnt == topv) |=> (cnt == '0));
  assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(cnt_wdata)));
endmodule

// File: rtl/tmr16_flags.sv
`timescale 1ns/1ps
module tmr16_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_set,
  input  logic       cmp_set,
  input  logic       ovf_ack,
  input  logic       cmp_ack,
  input  logic       clr_wr,
  input  logic [1:0] clr_bits,
  output logic       ovf,
  output logic       cmpf
);
  logic ovf_clr, cmp_clr;
  assign ovf_clr = ovf_ack || (clr_wr && clr_bits[0]);
  assign cmp_clr = cmp_ack || (clr_wr && clr_bits[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf  <= 1'b0;
      cmpf <= 1'b0;
    end else begin
      if (ovf_set)      ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (cmp_set)      cmpf <= 1'b1;
      else if (cmp_clr) cmpf <= 1'b0;
    end
  end

  assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf);
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_ack && !(clr_wr && clr_bits[0])) |=> ovf);
  assert_cmp_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_set |=> cmpf);
  assert_cmp_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpf && !cmp_ack && !(clr_wr && clr_bits[1])) |=> cmpf);
endmodule

// File: rtl/tmr16_ocpin.sv
`timescale 1ns/1ps
module tmr16_ocpin
  import tmr16_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic match_ev,
  input  oc_e  oc_mode,
  output logic pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else if (match_ev) begin
      case (oc_mode)
        OC_TOG:  pin <= ~pin;
        OC_CLR:  pin <= 1'b0;
        OC_SET:  pin <= 1'b1;
        default: ;
      endcase
    end
  end

  assert_pin_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_ev || oc_mode == OC_OFF) |=> $stable(pin));
  assert_pin_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && oc_mode == OC_SET) |=> pin);
  assert_pin_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && oc_mode == OC_CLR) |=> !pin);
endmodule

// File: rtl/tmr16_ctc.sv
`timescale 1ns/1ps
module tmr16_ctc
  import tmr16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              ovf_ack,
  input  logic              cmp_ack,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              oc_pin
);
  logic [CNT_W-1:0] cmpa, topv, cnt;
  logic [3:0]       mode_code;
  oc_e              oc_mode;
  run_e             run;
  logic             match_ev, wrap_ev, cnt_wr, flag_wr;

  assign run     = decode_mode(mode_code);
  assign cnt_wr  = wr_en && (addr == A_COUNT);
  assign flag_wr = wr_en && (addr == A_FLAGS);

  tmr16_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cmpa(cmpa), .topv(topv), .mode_code(mode_code), .oc_mode(oc_mode)
  );

  tmr16_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wdata(wdata), .run(run), .cmpa(cmpa), .topv(topv),
    .cnt(cnt), .match_ev(match_ev), .wrap_ev(wrap_ev)
  );

  tmr16_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ovf_set(wrap_ev), .cmp_set(match_ev),
    .ovf_ack(ovf_ack), .cmp_ack(cmp_ack), .clr_wr(flag_wr),
    .clr_bits(wdata[1:0]), .ovf(ovf_flag), .cmpf(cmp_flag)
  );

  tmr16_ocpin u_oc (
    .clk(clk), .rst_n(rst_n), .match_ev(match_ev), .oc_mode(oc_mode),
    .pin(oc_pin)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      A_COUNT: rdata = cnt;
      A_CMPA:  rdata = cmpa;
      A_TOP:   rdata = topv;
      A_CTRL:  rdata[5:0] = {oc_mode, mode_code};
      A_FLAGS: rdata[1:0] = {cmp_flag, ovf_flag};
      default: rdata = '0;
    endcase
  end
endmodule

// File: tb/tmr16_ctc_tb.sv
`timescale 1ns/1ps
module tmr16_ctc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, ovf_ack = 1'b0, cmp_ack = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ovf_flag, cmp_flag, oc_pin;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  tmr16_ctc u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .oc_pin(oc_pin)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    addr = a; #0.5; chk(tag, rdata, exp);
  endtask

  task automatic run(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset;
    rd(3'd0, 16'h0, "R1 count"); rd(3'd1, 16'h0, "R1 cmpa");
    rd(3'd2, 16'h0, "R1 top");   rd(3'd3, 16'h0, "R1 ctrl");
    rd(3'd4, 16'h0, "R1 flags");
    chk("R1 pin", {15'd0, oc_pin}, 16'd0);
  endtask

  task automatic t_gate;
    wr(3'd1, 16'h0100); wr(3'd0, 16'd5);
    repeat (3) @(negedge clk);
    rd(3'd0, 16'd5, "R2 hold without tick");
    run(4);
    rd(3'd0, 16'd9, "R2 four ticks");
  endtask

  task automatic t_free;
    wr(3'd3, 16'h0000); wr(3'd1, 16'd2); wr(3'd4, 16'h3); wr(3'd0, 16'd0);
    run(3);
    rd(3'd0, 16'd3, "R3 not cleared at compare");
    chk("R8 flag in free mode", {15'd0, cmp_flag}, 16'd1);
    wr(3'd0, 16'hFFFD); run(2);
    rd(3'd0, 16'hFFFF, "R3 reach max");
    chk("R4 no ovf before wrap", {15'd0, ovf_flag}, 16'd0);
    run(1);
    rd(3'd0, 16'h0000, "R3 wrap to zero");
    chk("R4 ovf with zero", {15'd0, ovf_flag}, 16'd1);
    run(3);
    chk("R4 ovf sticky", {15'd0, ovf_flag}, 16'd1);
    @(negedge clk); ovf_ack = 1'b1; @(negedge clk); ovf_ack = 1'b0;
    chk("R5 ack clears", {15'd0, ovf_flag}, 16'd0);
    wr(3'd0, 16'hFFFF); run(1);
    chk("R4 ovf again", {15'd0, ovf_flag}, 16'd1);
    wr(3'd4, 16'h0001);
    rd(3'd4, 16'h0002, "R5 write-1 clears only bit0, R8 bit1 kept");
    wr(3'd0, 16'hFFFF);
    @(negedge clk); tick = 1'b1; ovf_ack = 1'b1;
    @(negedge clk); tick = 1'b0; ovf_ack = 1'b0;
    chk("R5 set wins over ack", {15'd0, ovf_flag}, 16'd1);
  endtask

  task automatic t_clr_a;
    wr(3'd3, 16'h0004); wr(3'd1, 16'd3); wr(3'd4, 16'h3); wr(3'd0, 16'd0);
    run(3);
    rd(3'd0, 16'd3, "R6 reach compare");
    chk("R8 flag at match edge only", {15'd0, cmp_flag}, 16'd0);
    run(1);
    rd(3'd0, 16'd0, "R6 cleared after compare");
    chk("R8 flag set", {15'd0, cmp_flag}, 16'd1);
    run(6);
    rd(3'd0, 16'd2, "R6 period four");
  endtask

  task automatic t_clr_t;
    wr(3'd3, 16'h000C); wr(3'd2, 16'd5); wr(3'd1, 16'd2);
    wr(3'd4, 16'h3); wr(3'd0, 16'd0);
    run(5);
    rd(3'd0, 16'd5, "R7 passes compare A");
    chk("R8 flag in mode 12", {15'd0, cmp_flag}, 16'd1);
    run(1);
    rd(3'd0, 16'd0, "R7 cleared at top");
    @(negedge clk); cmp_ack = 1'b1; @(negedge clk); cmp_ack = 1'b0;
    chk("R8 ack clears", {15'd0, cmp_flag}, 16'd0);
  endtask

  task automatic t_pin;
    wr(3'd3, 16'h0014); wr(3'd1, 16'd1); wr(3'd0, 16'd0);
    run(1);
    chk("R9 no action before match", {15'd0, oc_pin}, 16'd0);
    run(1);
    chk("R9 toggle", {15'd0, oc_pin}, 16'd1);
    rd(3'd0, 16'd0, "R12 period with toggle");
    run(2);
    chk("R9 toggle back", {15'd0, oc_pin}, 16'd0);
    wr(3'd3, 16'h0034); run(2);
    chk("R9 set", {15'd0, oc_pin}, 16'd1);
    run(2);
    chk("R9 set holds", {15'd0, oc_pin}, 16'd1);
    rd(3'd0, 16'd0, "R12 period with set");
    wr(3'd3, 16'h0024); run(2);
    chk("R9 clear", {15'd0, oc_pin}, 16'd0);
    wr(3'd3, 16'h0034); run(2);
    wr(3'd3, 16'h0004); run(4);
    chk("R9 disconnected keeps pin", {15'd0, oc_pin}, 16'd1);
    rd(3'd0, 16'd0, "R12 period disconnected");
  endtask

  task automatic t_prio;
    wr(3'd3, 16'h0000); wr(3'd1, 16'd10); wr(3'd0, 16'd10); wr(3'd4, 16'h3);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; addr = 3'd0; wdata = 16'd100;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(3'd0, 16'd100, "R10 write beats increment");
    chk("R10 no match on write cycle", {15'd0, cmp_flag}, 16'd0);
  endtask

  task automatic t_reserved;
    wr(3'd3, 16'h0005); wr(3'd1, 16'd2); wr(3'd0, 16'd0);
    run(4);
    rd(3'd0, 16'd4, "R11 reserved code counts freely");
    wr(3'd3, 16'h0008); wr(3'd0, 16'hFFFF); wr(3'd4, 16'h1); run(1);
    chk("R11 reserved code wraps with ovf", {15'd0, ovf_flag}, 16'd1);
  endtask

  initial begin
    #10000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_gate;
    t_free;
    t_clr_a;
    t_clr_t;
    t_pin;
    t_prio;
    t_reserved;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule